// File: doc/BRIEF.md
# UART Receive Byte Queue

This block sits between the line-side receiver of a serial port and the register port that software reads. Each received byte, or each line-break indication, is offered on a one-cycle strobe. A control bit chooses where the byte goes. In queue mode it goes into a circular store of parameterised depth, 16 by default. In holding mode it overwrites a single holding register. Reads of the data register take the oldest queued byte, or the held byte in holding mode.

The block reports its state in three ways. A queue status word gives the occupancy, a full flag and an error-pending flag. A data-ready flag shows that a byte is waiting. An error status word collects overrun, parity, frame and break indications and clears itself when read. Two one-cycle pulses go to the interrupt logic: a receive event for every arrival and an error event for every lost byte or empty read. A self-clearing flush bit in the control write empties the queue.

The mode is held by a two-state machine. State MODE_HOLD is entered at reset and by the DISABLE transition, which is a control write with bit 0 clear. State MODE_FIFO is entered by the ENABLE transition, which is a control write with bit 0 set. Any other cycle stays in the current state. Stored bytes are kept across mode changes.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset the block is in holding mode (ctl_rdata = 0), fifo_stat = 0, data_ready = 0, err_ev = 0, rx_ev = 0, and a read of the error status returns 0.
- R2: In queue mode (ctl_wdata bit 0 = 1), bytes are returned by data reads in arrival order, one byte per read. fifo_stat[7:0] holds the number of stored bytes.
- R3: When DEPTH bytes are stored, fifo_stat[8] is 1 and fifo_stat[7:0] reads 0.
- R4: A byte that arrives in queue mode while the queue is full is dropped, even if a read takes place in the same cycle. err_ev pulses the cycle after, and rx_ev still pulses.
- R5: A data read in queue mode while the queue is empty returns 0 on rd_data and pulses err_ev the cycle after.
- R6: In queue mode, data_ready is 1 while at least one byte is stored and falls when a read removes the last byte.
- R7: An arrival and a read in the same cycle on a queue that is neither empty nor full leave the count unchanged. On an empty queue, the read returns 0 with an error event and the byte is stored.
- R8: In holding mode (ctl_wdata bit 0 = 0), each arrival overwrites the holding register and sets data_ready. A read returns the latest byte and clears data_ready. A repeated read returns the same byte and raises no error event.
- R9: A control write with bit 1 set empties the queue at that edge. Bytes arriving in the same cycle are discarded without an rx_ev. ctl_rdata bit 1 always reads 0 and bit 0 shows the mode.
- R10: A line-break strobe stores a 0x00 byte in the same way as a received byte and sets error status bit 3.
- R11: Error status bits are overrun (bit 0), parity (bit 1), frame (bit 2) and break (bit 3), fed by line_err[0..2] and line_brk. A read returns the value and clears it. A strobe in the same cycle as the read is kept for the next read. fifo_stat[9] is 1 while any error bit is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Control write data: bit 0 queue enable, bit 1 flush |
| ctl_rdata | output | 2 | Control read-back: bit 0 mode, bit 1 always 0 |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | DATA_W | Received byte |
| line_err | input | 3 | Line error strobes: bit 0 overrun, bit 1 parity, bit 2 frame |
| line_brk | input | 1 | Line-break strobe |
| data_rd | input | 1 | Data register read strobe |
| rd_data | output | DATA_W | Data returned by the last data read |
| data_ready | output | 1 | A byte is waiting |
| fifo_stat | output | 10 | Queue status: [7:0] count, [8] full, [9] error pending |
| err_rd | input | 1 | Error status read strobe |
| err_rdata | output | 4 | Error status returned by the last error read |
| err_ev | output | 1 | Error event pulse to the interrupt logic |
| rx_ev | output | 1 | Receive event pulse to the interrupt logic |

## Verification
Every result of this block comes from a register, so each one is due exactly one cycle after the edge that takes the strobe. This holds for the count, full and ready flags, rd_data, err_rdata, the control read-back and both event pulses. The bench drives a strobe on a falling edge and lets one rising edge pass. It then samples on the next falling edge, which is the single cycle in which an event pulse is visible, and clears the strobes before the following rising edge. Every table step and directed step follows this one-cycle rule, so no check depends on the order of processes at an edge.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [0:0] {
        MODE_HOLD = 1'b0,
        MODE_FIFO = 1'b1
    } rxq_mode_e;

    localparam int CTL_W         = 2;
    localparam int CTL_EN_BIT    = 0;
    localparam int CTL_FLUSH_BIT = 1;

    localparam int ERR_W   = 4;
    localparam int ERR_OVR = 0;
    localparam int ERR_PAR = 1;
    localparam int ERR_FRM = 2;
    localparam int ERR_BRK = 3;

    localparam int STAT_W        = 10;
    localparam int STAT_CNT_W    = 8;
    localparam int STAT_FULL_BIT = 8;
    localparam int STAT_ERR_BIT  = 9;

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ctl_wr,
    input  logic      ctl_en,
    output rxq_mode_e mode
);

    rxq_mode_e state_q;
    rxq_mode_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_HOLD;
        else        state_q <= state_d;
    end

    // transitions: ENABLE and DISABLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_HOLD: if (ctl_wr && ctl_en)  state_d = MODE_FIFO;
            MODE_FIFO: if (ctl_wr && !ctl_en) state_d = MODE_HOLD;
            default:   state_d = MODE_HOLD;
        endcase
    end

    // outputs
    always_comb begin
        mode = state_q;
    end

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr;
    logic [PTR_W-1:0]  rptr;
    logic              push_ok;
    logic              pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign push_ok = push && !full && !clr;
    assign pop_ok  = pop && !empty && !clr;
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + PTR_W'(1);
            if (pop_ok)  rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + PTR_W'(1);
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/rxq_errstat.sv
module rxq_errstat
    import rxq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] set,
    input  logic             rd,
    output logic [ERR_W-1:0] pending,
    output logic [ERR_W-1:0] rdata
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= '0;
            rdata   <= '0;
        end else if (rd) begin
            rdata   <= pending;
            pending <= set;
        end else begin
            pending <= pending | set;
        end
    end

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [1:0]        ctl_wdata,
    output logic [1:0]        ctl_rdata,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic [2:0]        line_err,
    input  logic              line_brk,
    input  logic              data_rd,
    output logic [DATA_W-1:0] rd_data,
    output logic              data_ready,
    output logic [9:0]        fifo_stat,
    input  logic              err_rd,
    output logic [3:0]        err_rdata,
    output logic              err_ev,
    output logic              rx_ev
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = PTR_W + 1;

    rxq_mode_e         mode;
    logic              fifo_on;
    logic              flush;
    logic              arrive;
    logic [DATA_W-1:0] arrive_byte;
    logic [DATA_W-1:0] head;
    logic [CNT_W-1:0]  count;
    logic              q_full;
    logic              q_empty;
    logic [ERR_W-1:0]  err_set;
    logic [ERR_W-1:0]  err_pend;
    logic [DATA_W-1:0] hold_q;
    logic              hold_rdy_q;
    logic [DATA_W-1:0] rd_data_q;
    logic              err_ev_q;
    logic              rx_ev_q;
    logic              drop;
    logic              under_rd;

    assign flush       = ctl_wr && ctl_wdata[CTL_FLUSH_BIT];
    assign fifo_on     = (mode == MODE_FIFO);
    assign arrive      = (rx_valid || line_brk) && !flush;
    assign arrive_byte = line_brk ? '0 : rx_byte;
    assign drop        = fifo_on && arrive && q_full;
    assign under_rd    = fifo_on && data_rd && q_empty && !flush;

    rxq_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl_wr (ctl_wr),
        .ctl_en (ctl_wdata[CTL_EN_BIT]),
        .mode   (mode)
    );

    rxq_store #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flush),
        .push  (fifo_on && arrive),
        .pop   (fifo_on && data_rd),
        .din   (arrive_byte),
        .head  (head),
        .count (count),
        .full  (q_full),
        .empty (q_empty)
    );

    always_comb begin
        err_set          = '0;
        err_set[ERR_OVR] = line_err[0];
        err_set[ERR_PAR] = line_err[1];
        err_set[ERR_FRM] = line_err[2];
        err_set[ERR_BRK] = line_brk;
    end

    rxq_errstat u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (err_set),
        .rd      (err_rd),
        .pending (err_pend),
        .rdata   (err_rdata)
    );

    // holding register path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q     <= '0;
            hold_rdy_q <= 1'b0;
        end else if (!fifo_on) begin
            if (arrive) begin
                hold_q     <= arrive_byte;
                hold_rdy_q <= 1'b1;
            end else if (data_rd) begin
                hold_rdy_q <= 1'b0;
            end
        end
    end

    // read data and event pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_q <= '0;
            err_ev_q  <= 1'b0;
            rx_ev_q   <= 1'b0;
        end else begin
            if (data_rd) begin
                if (!fifo_on)                  rd_data_q <= hold_q;
                else if (q_empty || flush)     rd_data_q <= '0;
                else                           rd_data_q <= head;
            end
            err_ev_q <= drop || under_rd;
            rx_ev_q  <= arrive;
        end
    end

    always_comb begin
        fifo_stat                                = '0;
        fifo_stat[STAT_CNT_W-1:0]                = q_full ? '0 : STAT_CNT_W'(count);
        fifo_stat[STAT_FULL_BIT]                 = q_full;
        fifo_stat[STAT_ERR_BIT]                  = |err_pend;
    end

    assign ctl_rdata  = {1'b0, fifo_on};
    assign data_ready = fifo_on ? !q_empty : hold_rdy_q;
    assign rd_data    = rd_data_q;
    assign err_ev     = err_ev_q;
    assign rx_ev      = rx_ev_q;

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_wr,
    input logic [1:0] ctl_wdata,
    input logic [1:0] ctl_rdata,
    input logic       rx_valid,
    input logic [2:0] line_err,
    input logic       line_brk,
    input logic       data_rd,
    input logic [7:0] rd_data,
    input logic       data_ready,
    input logic [9:0] fifo_stat,
    input logic       err_rd,
    input logic       err_ev,
    input logic       rx_ev
);

    logic in_q;
    logic q_empty;
    assign in_q    = ctl_rdata[0];
    assign q_empty = !fifo_stat[8] && (fifo_stat[7:0] == 8'd0);

    p_full_zero_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_stat[8] |-> fifo_stat[7:0] == 8'd0);

    p_drop_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_q && rx_valid && fifo_stat[8] && !ctl_wr) |=> (err_ev && rx_ev));

    p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_q && data_rd && q_empty && !ctl_wr) |=> (err_ev && rd_data == 8'd0));

    p_ready_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_q |-> (data_ready == !q_empty));

    p_same_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_q && rx_valid && data_rd && !ctl_wr && !fifo_stat[8] && !q_empty)
        |=> fifo_stat[8:0] == $past(fifo_stat[8:0]));

    p_hold_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_q && rx_valid && !ctl_wr) |=> data_ready);

    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wdata[1]) |=> (fifo_stat[8:0] == 9'd0 && !rx_ev));

    p_break_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        line_brk |=> fifo_stat[9]);

    p_err_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_rd && line_err == 3'd0 && !line_brk) |=> !fifo_stat[9]);

endmodule

bind uart_rx_queue rxq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (ctl_wdata),
    .ctl_rdata  (ctl_rdata),
    .rx_valid   (rx_valid),
    .line_err   (line_err),
    .line_brk   (line_brk),
    .data_rd    (data_rd),
    .rd_data    (rd_data),
    .data_ready (data_ready),
    .fifo_stat  (fifo_stat),
    .err_rd     (err_rd),
    .err_ev     (err_ev),
    .rx_ev      (rx_ev)
);

// File: tb/sim_uart_rx_queue.sv
module sim_uart_rx_queue;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [1:0] ctl_wdata = '0;
    logic [1:0] ctl_rdata;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic [2:0] line_err = '0;
    logic       line_brk = 1'b0;
    logic       data_rd = 1'b0;
    logic [7:0] rd_data;
    logic       data_ready;
    logic [9:0] fifo_stat;
    logic       err_rd = 1'b0;
    logic [3:0] err_rdata;
    logic       err_ev;
    logic       rx_ev;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    uart_rx_queue u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .line_err(line_err), .line_brk(line_brk), .data_rd(data_rd),
        .rd_data(rd_data), .data_ready(data_ready), .fifo_stat(fifo_stat),
        .err_rd(err_rd), .err_rdata(err_rdata), .err_ev(err_ev), .rx_ev(rx_ev)
    );

    // op codes of the table
    localparam logic [2:0] OP_PUSH = 3'd0;
    localparam logic [2:0] OP_POP  = 3'd1;
    localparam logic [2:0] OP_BRK  = 3'd2;
    localparam logic [2:0] OP_CTL  = 3'd3;
    localparam logic [2:0] OP_PP   = 3'd4;

    // {op, arg, expected rd_data, expected count, expected ready, expected err_ev}
    localparam int NV = 13;
    localparam logic [28:0] VEC [NV] = '{
        {OP_CTL,  8'h01, 8'h00, 8'd0, 1'b0, 1'b0},
        {OP_PUSH, 8'h41, 8'h00, 8'd1, 1'b1, 1'b0},
        {OP_PUSH, 8'h42, 8'h00, 8'd2, 1'b1, 1'b0},
        {OP_PP,   8'h43, 8'h41, 8'd2, 1'b1, 1'b0},
        {OP_POP,  8'h00, 8'h42, 8'd1, 1'b1, 1'b0},
        {OP_POP,  8'h00, 8'h43, 8'd0, 1'b0, 1'b0},
        {OP_POP,  8'h00, 8'h00, 8'd0, 1'b0, 1'b1},
        {OP_BRK,  8'h00, 8'h00, 8'd1, 1'b1, 1'b0},
        {OP_POP,  8'h00, 8'h00, 8'd0, 1'b0, 1'b0},
        {OP_PUSH, 8'h55, 8'h00, 8'd1, 1'b1, 1'b0},
        {OP_CTL,  8'h03, 8'h00, 8'd0, 1'b0, 1'b0},
        {OP_PP,   8'h66, 8'h00, 8'd1, 1'b1, 1'b1},
        {OP_POP,  8'h00, 8'h66, 8'd0, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive strobes at a falling edge, let one rising edge pass, sample at the next falling edge
    task automatic step();
        @(negedge clk);
        ctl_wr = 1'b0; rx_valid = 1'b0; line_brk = 1'b0; line_err = '0;
        data_rd = 1'b0; err_rd = 1'b0;
    endtask

    task automatic do_op(input logic [2:0] op, input logic [7:0] arg);
        case (op)
            OP_PUSH: begin rx_valid = 1'b1; rx_byte = arg; end
            OP_POP:  data_rd = 1'b1;
            OP_BRK:  line_brk = 1'b1;
            OP_CTL:  begin ctl_wr = 1'b1; ctl_wdata = arg[1:0]; end
            OP_PP:   begin rx_valid = 1'b1; rx_byte = arg; data_rd = 1'b1; end
            default: ;
        endcase
        step();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ctl_rdata", 32'(ctl_rdata), 32'd0);
        chk("R1 fifo_stat", 32'(fifo_stat), 32'd0);
        chk("R1 data_ready", 32'(data_ready), 32'd0);
        chk("R1 err_ev", 32'(err_ev), 32'd0);
        chk("R1 rx_ev", 32'(rx_ev), 32'd0);
        err_rd = 1'b1; step();
        chk("R1 err_rdata", 32'(err_rdata), 32'd0);

        // table walk: R2 R5 R6 R7 R9 R10 in queue mode
        for (int i = 0; i < NV; i++) begin
            logic [2:0] op;
            op = VEC[i][28:26];
            do_op(op, VEC[i][25:18]);
            if (op == OP_POP || op == OP_PP)
                chk($sformatf("R2 R5 R7 rd_data step %0d", i), 32'(rd_data), 32'(VEC[i][17:10]));
            chk($sformatf("R2 R7 R9 R10 count step %0d", i), 32'(fifo_stat[8:0]), 32'(VEC[i][9:2]));
            chk($sformatf("R6 ready step %0d", i), 32'(data_ready), 32'(VEC[i][1]));
            chk($sformatf("R5 R7 err_ev step %0d", i), 32'(err_ev), 32'(VEC[i][0]));
        end

        // R3 / R4 fill to full and overflow
        for (int i = 0; i < 16; i++) begin
            do_op(OP_PUSH, 8'(i * 3 + 1));
            if (i == 14) chk("R3 count before full", 32'(fifo_stat[8:0]), 32'd15);
        end
        chk("R3 full flag", 32'(fifo_stat[8]), 32'd1);
        chk("R3 count field zero", 32'(fifo_stat[7:0]), 32'd0);
        do_op(OP_PP, 8'hEE);
        chk("R4 err_ev on drop", 32'(err_ev), 32'd1);
        chk("R4 rx_ev on drop", 32'(rx_ev), 32'd1);
        chk("R4 first byte", 32'(rd_data), 32'd1);
        chk("R4 count after drop", 32'(fifo_stat[8:0]), 32'd15);
        for (int i = 1; i < 16; i++) begin
            do_op(OP_POP, 8'h00);
            chk($sformatf("R2 order %0d", i), 32'(rd_data), 32'(8'(i * 3 + 1)));
        end
        chk("R6 ready after drain", 32'(data_ready), 32'd0);
        chk("R4 dropped byte absent", 32'(fifo_stat[8:0]), 32'd0);

        // R9 flush with a concurrent arrival
        do_op(OP_PUSH, 8'h12);
        rx_valid = 1'b1; rx_byte = 8'h34; ctl_wr = 1'b1; ctl_wdata = 2'b11;
        step();
        chk("R9 flushed count", 32'(fifo_stat[8:0]), 32'd0);
        chk("R9 no rx_ev", 32'(rx_ev), 32'd0);
        chk("R9 ctl read-back", 32'(ctl_rdata), 32'd1);

        // R8 holding mode
        do_op(OP_CTL, 8'h00);
        chk("R8 ctl hold", 32'(ctl_rdata), 32'd0);
        do_op(OP_PUSH, 8'h11);
        do_op(OP_PUSH, 8'h22);
        chk("R8 ready set", 32'(data_ready), 32'd1);
        do_op(OP_POP, 8'h00);
        chk("R8 latest byte", 32'(rd_data), 32'h22);
        chk("R8 ready cleared", 32'(data_ready), 32'd0);
        do_op(OP_POP, 8'h00);
        chk("R8 repeat byte", 32'(rd_data), 32'h22);
        chk("R8 no err_ev", 32'(err_ev), 32'd0);

        // R11 / R10 error status
        err_rd = 1'b1; step();
        line_err = 3'b011; step();
        chk("R11 pending flag", 32'(fifo_stat[9]), 32'd1);
        err_rd = 1'b1; step();
        chk("R11 read value", 32'(err_rdata), 32'h3);
        chk("R11 cleared", 32'(fifo_stat[9]), 32'd0);
        line_brk = 1'b1; step();
        err_rd = 1'b1; step();
        chk("R10 break bit", 32'(err_rdata), 32'h8);
        err_rd = 1'b1; line_err = 3'b100; step();
        chk("R11 read with strobe", 32'(err_rdata), 32'h0);
        err_rd = 1'b1; step();
        chk("R11 strobe kept", 32'(err_rdata), 32'h4);

        done = 1'b1;
        finish_run();
    end

endmodule